// File: doc/BRIEF.md
# SPI Burst Transfer Engine

This block is the serial shifting core of an SPI master. It clocks a burst of 8-bit words on the serial clock. Before a burst, the controlling logic sets two 24-bit counts. The first is the total number of words to clock. The second is how many of those words are taken from an external transmit FIFO. After that many words, the engine shifts out zero words. Each received word is either pushed into an external receive FIFO or dropped. One burst can therefore be transmit-only, receive-only or mixed.

The serial clock timing comes from an external divider. It supplies a single-cycle tick once per half-period of the serial clock. Clock polarity, clock phase and bit order are captured when a burst starts. Four chip-select lines are available. The selected line can follow the burst automatically, or it can be held at a level set directly. A polarity input sets both the active level and the idle level of every line.

A burst starts with a one-cycle start strobe. The busy flag stays high for the whole burst. At the end, a one-cycle done pulse is issued and busy clears in the same cycle.

Top module: `spi_burst_engine`

## Requirements
- R1: A start strobe with a non-zero burst count while idle raises busy in the next cycle. Busy stays high until the burst ends. Done is a one-cycle pulse, and busy falls in the same cycle as that pulse.
- R2: A burst of N words makes exactly 16·N serial-clock transitions. The serial clock rests at the captured polarity level between words and returns to it at the end of the burst.
- R3: The first min(tx_len, burst_len) words are popped from the transmit FIFO in order, with one pop per word. The remaining words of the burst are sent as 0x00.
- R4: With phase 0, mosi holds each bit before the leading edge and miso is sampled on the leading edge. With phase 1, mosi changes on the leading edge and miso is sampled on the trailing edge. The leading edge is the edge that leaves the polarity level.
- R5: With lsb_first=1, bit 0 of each word is sent and received first. With lsb_first=0, bit 7 goes first. The setting applies in both directions.
- R6: With drop_rx=0, each received word is pushed to the receive FIFO one cycle after its last clock edge, in arrival order. With drop_rx=1, nothing is pushed.
- R7: If a transmit word is due and the transmit FIFO is empty, the engine stalls. During the stall the serial clock stays at its idle level and makes no edge. The burst resumes when a word arrives.
- R8: In automatic mode, chip-select line cs_sel is at its active level from the first cycle after the start until the done cycle. The active level is 0 when cs_active_low=1 and 1 otherwise. The line goes active at least one cycle before the first clock edge and stays active at least one cycle after the last edge. All other lines sit at the idle level, which equals cs_active_low.
- R9: With cs_manual=1, line cs_sel is driven to cs_level and all other lines sit at the idle level.
- R10: A start strobe with burst_len=0 gives a done pulse in the next cycle. It makes no busy cycle and no clock edge.
- R11: A start strobe while busy is ignored. The running burst keeps its count and mode.
- R12: After reset: busy=0, done=0, sclk=0, no FIFO pop or push, and every chip-select line is at the idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Clock phase |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_drop_rx | input | 1 | 1: discard received words |
| cfg_cs_sel | input | 2 | Chip-select index |
| cfg_cs_manual | input | 1 | 1: chip select driven from cfg_cs_level |
| cfg_cs_level | input | 1 | Manual chip-select level |
| cfg_cs_active_low | input | 1 | 1: chip selects are active low and idle high |
| burst_len | input | 24 | Total words in the burst |
| tx_len | input | 24 | Words taken from the transmit FIFO |
| start_wr | input | 1 | One-cycle start strobe |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle completion pulse |
| sclk_tick | input | 1 | Half-period tick from the clock divider |
| txf_data | input | 8 | Transmit FIFO head word |
| txf_empty | input | 1 | Transmit FIFO empty |
| txf_pop | output | 1 | Transmit FIFO pop |
| rxf_data | output | 8 | Received word |
| rxf_push | output | 1 | Receive FIFO push |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| spi_cs | output | 4 | Chip-select lines |

## Verification
- Busy is due one cycle after the start strobe is sampled, and the zero-count done pulse is due in that same cycle. Every such check is taken at the falling edge that follows.
- Chip-select levels are combinational from registered state and from the configuration inputs, so they are checked at the falling edge after the inputs change.
- Serial-line results depend on tick timing, so they are not tied to fixed cycle numbers. A slave model watches sclk, mosi and the chip selects at every falling edge, drives miso, and records the words it captures and the edges it counts. After the done pulse, the bench waits two more cycles, so that the final receive push has landed. It then compares the captured words, the pop and push counts and the edge count with values computed from the stimulus.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL
  } state_t;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb_first;
    logic drop_rx;
  } mode_t;
endpackage

// File: rtl/spi_burst_ctrl.sv
module spi_burst_ctrl
  import spi_burst_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int WORD_W = 8,
  parameter int EDGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  burst_len_i,
  input  logic [CNT_W-1:0]  tx_len_i,
  input  mode_t             mode_i,
  input  logic              tick_i,
  input  logic [WORD_W-1:0] txf_data_i,
  input  logic              txf_empty_i,
  output mode_t             mode_o,
  output logic              sclk_o,
  output logic [EDGE_W-1:0] edge_idx_o,
  output logic              shift_tick_o,
  output logic              load_o,
  output logic [WORD_W-1:0] load_data_o,
  output logic              txf_pop_o,
  output logic              rxf_push_o,
  output logic              done_o,
  output logic              busy_o
);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * WORD_W - 1);
  localparam logic [CNT_W-1:0]  ONE       = CNT_W'(1);

  state_t            st_q, st_d;
  mode_t             mode_q, mode_d;
  logic              sclk_q, sclk_d;
  logic [EDGE_W-1:0] edge_q, edge_d;
  logic [CNT_W-1:0]  words_q, words_d;
  logic [CNT_W-1:0]  txleft_q, txleft_d;
  logic              first_q, first_d;
  logic              push_q, push_d;
  logic              done_q, done_d;
  logic              tx_due;
  logic              load_c, pop_c;

  assign tx_due = (txleft_q != '0);

  always_comb begin
    st_d     = st_q;
    mode_d   = mode_q;
    sclk_d   = sclk_q;
    edge_d   = edge_q;
    words_d  = words_q;
    txleft_d = txleft_q;
    first_d  = first_q;
    push_d   = 1'b0;
    done_d   = 1'b0;
    load_c   = 1'b0;
    pop_c    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        sclk_d = mode_i.cpol;
        if (start_i) begin
          if (burst_len_i == '0) begin
            done_d = 1'b1;
          end else begin
            st_d     = ST_FETCH;
            mode_d   = mode_i;
            words_d  = burst_len_i;
            txleft_d = tx_len_i;
            first_d  = 1'b1;
          end
        end
      end
      ST_FETCH: begin
        if (!tx_due || !txf_empty_i) begin
          load_c = 1'b1;
          pop_c  = tx_due;
          if (tx_due) txleft_d = txleft_q - ONE;
          edge_d = '0;
          st_d   = first_q ? ST_LEAD : ST_SHIFT;
        end
      end
      ST_LEAD: begin
        if (tick_i) begin
          st_d    = ST_SHIFT;
          first_d = 1'b0;
        end
      end
      ST_SHIFT: begin
        if (tick_i) begin
          sclk_d = ~sclk_q;
          edge_d = edge_q + EDGE_W'(1);
          if (edge_q == LAST_EDGE) begin
            words_d = words_q - ONE;
            push_d  = ~mode_q.drop_rx;
            st_d    = (words_q == ONE) ? ST_TRAIL : ST_FETCH;
          end
        end
      end
      ST_TRAIL: begin
        if (tick_i) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      mode_q   <= '0;
      sclk_q   <= 1'b0;
      edge_q   <= '0;
      words_q  <= '0;
      txleft_q <= '0;
      first_q  <= 1'b0;
      push_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      mode_q   <= mode_d;
      sclk_q   <= sclk_d;
      edge_q   <= edge_d;
      words_q  <= words_d;
      txleft_q <= txleft_d;
      first_q  <= first_d;
      push_q   <= push_d;
      done_q   <= done_d;
    end
  end

  assign mode_o       = mode_q;
  assign sclk_o       = sclk_q;
  assign edge_idx_o   = edge_q;
  assign shift_tick_o = (st_q == ST_SHIFT) && tick_i;
  assign load_o       = load_c;
  assign load_data_o  = tx_due ? txf_data_i : '0;
  assign txf_pop_o    = pop_c;
  assign rxf_push_o   = push_q;
  assign done_o       = done_q;
  assign busy_o       = (st_q != ST_IDLE);

  // R1: completion is a single-cycle pulse
  p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R1: busy only ends together with the done pulse
  p_busy_end_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(busy_o) |-> done_q);
  // R7: while waiting for a word the serial clock rests at idle
  p_stall_idle_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_FETCH) |-> (sclk_q == mode_q.cpol));
  // R6: no push in discard mode
  p_push_keep_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    rxf_push_o |-> !mode_q.drop_rx);
  // R10: zero-length start completes at once
  p_zero_burst_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_IDLE && start_i && burst_len_i == '0) |=> (done_q && st_q == ST_IDLE));
  // R11: a start during a burst leaves the captured mode alone
  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_SHIFT && start_i) |=> $stable(mode_q));
endmodule

// File: rtl/spi_burst_shift.sv
module spi_burst_shift #(
  parameter int WORD_W = 8,
  parameter int EDGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_data_i,
  input  logic              shift_tick_i,
  input  logic [EDGE_W-1:0] edge_idx_i,
  input  logic              cpha_i,
  input  logic              lsb_first_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [WORD_W-1:0] rx_word_o
);
  logic [WORD_W-1:0] tx_q, tx_d;
  logic [WORD_W-1:0] rx_q, rx_d;
  logic              sample_edge;
  logic              advance_edge;

  // even edge index = leading edge; phase 0 samples there, phase 1 on trailing
  assign sample_edge  = ~edge_idx_i[0] ^ cpha_i;
  assign advance_edge = ~sample_edge && !(cpha_i && edge_idx_i == '0);

  always_comb begin
    tx_d = tx_q;
    rx_d = rx_q;
    if (load_i) begin
      tx_d = load_data_i;
    end else if (shift_tick_i && advance_edge) begin
      tx_d = lsb_first_i ? {1'b0, tx_q[WORD_W-1:1]} : {tx_q[WORD_W-2:0], 1'b0};
    end
    if (shift_tick_i && sample_edge) begin
      rx_d = lsb_first_i ? {miso_i, rx_q[WORD_W-1:1]} : {rx_q[WORD_W-2:0], miso_i};
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign mosi_o    = lsb_first_i ? tx_q[0] : tx_q[WORD_W-1];
  assign rx_word_o = rx_q;

  // R4: the output bit does not move on a sampling edge
  p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (shift_tick_i && sample_edge) |=> $stable(mosi_o));
endmodule

// File: rtl/spi_burst_csgen.sv
module spi_burst_csgen #(
  parameter int NUM_CS = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  cs_sel_i,
  input  logic              manual_i,
  input  logic              level_i,
  input  logic              active_low_i,
  input  logic              auto_on_i,
  output logic [NUM_CS-1:0] cs_o
);
  logic [NUM_CS-1:0] active_vec;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_line
    logic sel_here;
    assign sel_here = (cs_sel_i == IDX_W'(g));
    assign cs_o[g]  = !sel_here ? active_low_i :
                      manual_i  ? level_i :
                      auto_on_i ? ~active_low_i : active_low_i;
    assign active_vec[g] = cs_o[g] ^ active_low_i;
  end

  // R8: at most one line is ever at its active level
  p_cs_onehot_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(active_vec));
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
  import spi_burst_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int WORD_W   = 8,
  parameter int NUM_CS   = 4,
  localparam int CS_IDX_W = $clog2(NUM_CS),
  localparam int EDGE_W   = $clog2(2 * WORD_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_cpol,
  input  logic                cfg_cpha,
  input  logic                cfg_lsb_first,
  input  logic                cfg_drop_rx,
  input  logic [CS_IDX_W-1:0] cfg_cs_sel,
  input  logic                cfg_cs_manual,
  input  logic                cfg_cs_level,
  input  logic                cfg_cs_active_low,
  input  logic [CNT_W-1:0]    burst_len,
  input  logic [CNT_W-1:0]    tx_len,
  input  logic                start_wr,
  output logic                busy,
  output logic                done,
  input  logic                sclk_tick,
  input  logic [WORD_W-1:0]   txf_data,
  input  logic                txf_empty,
  output logic                txf_pop,
  output logic [WORD_W-1:0]   rxf_data,
  output logic                rxf_push,
  output logic                sclk,
  output logic                mosi,
  input  logic                miso,
  output logic [NUM_CS-1:0]   spi_cs
);
  logic [1:0]        rst_sync_q;
  logic              rst_ni;
  mode_t             mode_in, mode_run;
  logic [EDGE_W-1:0] edge_idx;
  logic              shift_tick;
  logic              load;
  logic [WORD_W-1:0] load_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  assign mode_in = '{cpol: cfg_cpol, cpha: cfg_cpha,
                     lsb_first: cfg_lsb_first, drop_rx: cfg_drop_rx};

  spi_burst_ctrl #(.CNT_W(CNT_W), .WORD_W(WORD_W), .EDGE_W(EDGE_W)) u_ctrl (
    .clk          (clk),
    .rst_ni       (rst_ni),
    .start_i      (start_wr),
    .burst_len_i  (burst_len),
    .tx_len_i     (tx_len),
    .mode_i       (mode_in),
    .tick_i       (sclk_tick),
    .txf_data_i   (txf_data),
    .txf_empty_i  (txf_empty),
    .mode_o       (mode_run),
    .sclk_o       (sclk),
    .edge_idx_o   (edge_idx),
    .shift_tick_o (shift_tick),
    .load_o       (load),
    .load_data_o  (load_data),
    .txf_pop_o    (txf_pop),
    .rxf_push_o   (rxf_push),
    .done_o       (done),
    .busy_o       (busy)
  );

  spi_burst_shift #(.WORD_W(WORD_W), .EDGE_W(EDGE_W)) u_shift (
    .clk          (clk),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .load_data_i  (load_data),
    .shift_tick_i (shift_tick),
    .edge_idx_i   (edge_idx),
    .cpha_i       (mode_run.cpha),
    .lsb_first_i  (mode_run.lsb_first),
    .miso_i       (miso),
    .mosi_o       (mosi),
    .rx_word_o    (rxf_data)
  );

  spi_burst_csgen #(.NUM_CS(NUM_CS), .IDX_W(CS_IDX_W)) u_cs (
    .clk          (clk),
    .rst_ni       (rst_ni),
    .cs_sel_i     (cfg_cs_sel),
    .manual_i     (cfg_cs_manual),
    .level_i      (cfg_cs_level),
    .active_low_i (cfg_cs_active_low),
    .auto_on_i    (busy),
    .cs_o         (spi_cs)
  );
endmodule

// File: tb/spi_burst_engine_test.sv
`timescale 1ns/1ps
module spi_burst_engine_test;
  localparam int CLK_NS   = 8;
  localparam int TICK_DIV = 3;
  localparam int NV       = 6;
  // [21] cpol [20] cpha [19] lsb_first [18] drop_rx [17:16] cs_sel [15:8] burst [7:0] tx
  localparam logic [21:0] VEC [NV] = '{
    {4'b0000, 2'd0, 8'd3, 8'd3},
    {4'b0100, 2'd1, 8'd4, 8'd2},
    {4'b1010, 2'd2, 8'd2, 8'd0},
    {4'b1111, 2'd3, 8'd3, 8'd3},
    {4'b0010, 2'd0, 8'd1, 8'd5},
    {4'b1100, 2'd1, 8'd5, 8'd5}
  };

  logic clk, rst_n;
  logic cfg_cpol, cfg_cpha, cfg_lsb_first, cfg_drop_rx;
  logic [1:0] cfg_cs_sel;
  logic cfg_cs_manual, cfg_cs_level, cfg_cs_active_low;
  logic [23:0] burst_len, tx_len;
  logic start_wr, busy, done, sclk_tick;
  logic [7:0] txf_data, rxf_data;
  logic txf_empty, txf_pop, rxf_push, sclk, mosi, miso;
  logic [3:0] spi_cs;

  spi_burst_engine uut (.*);

  int nchecks = 0, nerr = 0;
  logic [7:0] tq [64];
  logic [7:0] rq [64];
  logic [7:0] mrx [16];
  int head, tail = 0, rcnt, dcnt;
  int tick_ph = 0;

  initial clk = 1'b0;
  always #(CLK_NS / 2) clk = ~clk;

  initial begin
    sclk_tick = 1'b0;
    forever begin
      @(negedge clk);
      tick_ph   = (tick_ph + 1) % TICK_DIV;
      sclk_tick = (tick_ph == 0);
    end
  end

  assign txf_empty = (head == tail);
  assign txf_data  = tq[head % 64];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= 0; rcnt <= 0; dcnt <= 0;
    end else begin
      if (txf_pop) head <= head + 1;
      if (rxf_push) begin
        rq[rcnt % 64] <= rxf_data;
        rcnt <= rcnt + 1;
      end
      if (done) dcnt <= dcnt + 1;
    end
  end

  function automatic logic [7:0] spat(input int i);
    return 8'(8'hA5 ^ (i * 29));
  endfunction

  function automatic int bitpos(input int idx);
    return cfg_lsb_first ? (idx % 8) : (7 - idx % 8);
  endfunction

  // slave model on the serial pins
  logic act, prev_act = 1'b0, prev_sclk = 1'b0, leading, seen_edge;
  int out_idx, lead_cnt, cap_cnt, edges = 0, lead_cyc, since_edge, lead_gap, trail_gap;
  logic [7:0] sb;
  always @(negedge clk) begin
    act = !cfg_cs_manual && (spi_cs[cfg_cs_sel] == ~cfg_cs_active_low);
    if (act && !prev_act) begin
      out_idx = 0; lead_cnt = 0; cap_cnt = 0; edges = 0;
      lead_cyc = 0; since_edge = 0; seen_edge = 1'b0;
    end
    if (act) begin
      if (sclk != prev_sclk) begin
        leading = (prev_sclk == cfg_cpol);
        if (!seen_edge) begin lead_gap = lead_cyc; seen_edge = 1'b1; end
        edges++;
        since_edge = 0;
        if (leading == !cfg_cpha) begin
          mrx[(cap_cnt / 8) % 16][bitpos(cap_cnt)] = mosi;
          cap_cnt++;
        end else if (cfg_cpha) begin
          out_idx = lead_cnt; lead_cnt++;
        end else begin
          out_idx++;
        end
      end else begin
        since_edge++;
        if (!seen_edge) lead_cyc++;
      end
    end
    if (!act && prev_act) trail_gap = since_edge;
    prev_act  = act;
    prev_sclk = sclk;
    sb   = spat(out_idx / 8);
    miso = sb[bitpos(out_idx)];
  end

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    nchecks++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic push_tx(input int n);
    for (int j = 0; j < n; j++) begin
      tq[tail % 64] = 8'(8'h3C + tail * 7);
      tail++;
    end
  endtask

  task automatic wait_done(input int db);
    int n = 0;
    while (dcnt == db && n < 5000) begin @(negedge clk); n++; end
    chk("R1", "done seen", 32'(dcnt != db), 1);
  endtask

  task automatic pulse_start();
    start_wr = 1'b1;
    @(negedge clk);
    start_wr = 1'b0;
  endtask

  task automatic run_vec(input int i);
    logic [21:0] v = VEC[i];
    int b = int'(v[15:8]), t = int'(v[7:0]), np, hb, rb, db;
    np = (t < b) ? t : b;
    @(negedge clk);
    {cfg_cpol, cfg_cpha, cfg_lsb_first, cfg_drop_rx} = v[21:18];
    cfg_cs_sel = v[17:16];
    burst_len  = 24'(b);
    tx_len     = 24'(t);
    push_tx(np);
    @(negedge clk);
    hb = head; rb = rcnt; db = dcnt;
    pulse_start();
    chk("R1", "busy after start", 32'(busy), 1);
    wait_done(db);
    repeat (2) @(negedge clk);
    chk("R1", "single done", 32'(dcnt - db), 1);
    chk("R1", "busy cleared", 32'(busy), 0);
    chk("R2", "edge count", 32'(edges), 32'(16 * b));
    chk("R2", "sclk idle level", 32'(sclk), 32'(cfg_cpol));
    chk("R3", "pop count", 32'(head - hb), 32'(np));
    for (int j = 0; j < b; j++)
      chk("R3/R4/R5", "mosi word", 32'(mrx[j]), (j < t) ? 32'(tq[(hb + j) % 64]) : 0);
    chk("R6", "push count", 32'(rcnt - rb), cfg_drop_rx ? 0 : 32'(b));
    if (!cfg_drop_rx)
      for (int j = 0; j < b; j++)
        chk("R6/R4/R5", "rx word", 32'(rq[(rb + j) % 64]), 32'(spat(j)));
    chk("R8", "cs idle after", 32'(spi_cs), 32'({4{cfg_cs_active_low}}));
    chk("R8", "lead gap", 32'(lead_gap > 0), 1);
    chk("R8", "trail gap", 32'(trail_gap > 0), 1);
  endtask

  bit finished = 1'b0;
  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchecks++; nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    int db, hb;
    rst_n = 1'b0; start_wr = 1'b0;
    cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_lsb_first = 1'b0; cfg_drop_rx = 1'b0;
    cfg_cs_sel = 2'd0; cfg_cs_manual = 1'b0; cfg_cs_level = 1'b0; cfg_cs_active_low = 1'b1;
    burst_len = '0; tx_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk("R12", "busy", 32'(busy), 0);
    chk("R12", "done", 32'(done), 0);
    chk("R12", "sclk", 32'(sclk), 0);
    chk("R12", "cs idle", 32'(spi_cs), 32'hF);
    chk("R12", "pop/push", 32'({txf_pop, rxf_push}), 0);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R10 zero-length burst
    burst_len = '0; tx_len = 24'd3;
    @(negedge clk);
    db = dcnt;
    start_wr = 1'b1;
    @(negedge clk);
    start_wr = 1'b0;
    chk("R10", "done pulse", 32'(done), 1);
    chk("R10", "no busy", 32'(busy), 0);
    chk("R10", "no pop", 32'(head), 32'(tail));

    // R11 start during a burst is ignored
    cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_cs_sel = 2'd0; cfg_drop_rx = 1'b1;
    burst_len = 24'd2; tx_len = '0;
    repeat (2) @(negedge clk);
    db = dcnt;
    pulse_start();
    repeat (20) @(negedge clk);
    burst_len = 24'd7; cfg_cpha = 1'b1;
    pulse_start();
    wait_done(db);
    repeat (2) @(negedge clk);
    chk("R11", "edge count kept", 32'(edges), 32);
    chk("R11", "single done", 32'(dcnt - db), 1);

    // R7 stall on empty transmit FIFO
    cfg_cpol = 1'b1; cfg_cpha = 1'b0; cfg_lsb_first = 1'b0; cfg_drop_rx = 1'b1;
    burst_len = 24'd2; tx_len = 24'd2;
    push_tx(1);
    repeat (2) @(negedge clk);
    db = dcnt; hb = head;
    pulse_start();
    repeat (150) @(negedge clk);
    chk("R7", "edges while stalled", 32'(edges), 16);
    chk("R7", "sclk idle in stall", 32'(sclk), 1);
    chk("R7", "busy in stall", 32'(busy), 1);
    push_tx(1);
    wait_done(db);
    repeat (2) @(negedge clk);
    chk("R7", "edges after resume", 32'(edges), 32);
    chk("R7", "second word", 32'(mrx[1]), 32'(tq[(hb + 1) % 64]));

    // R9 manual chip select
    cfg_cs_manual = 1'b1; cfg_cs_sel = 2'd2; cfg_cs_level = 1'b0; cfg_cs_active_low = 1'b1;
    @(negedge clk);
    chk("R9", "manual low", 32'(spi_cs), 32'b1011);
    cfg_cs_level = 1'b1;
    @(negedge clk);
    chk("R9", "manual high", 32'(spi_cs), 32'hF);
    cfg_cs_active_low = 1'b0; cfg_cs_sel = 2'd1;
    @(negedge clk);
    chk("R9", "manual active-high", 32'(spi_cs), 32'b0010);
    cfg_cs_manual = 1'b0;
    @(negedge clk);
    chk("R8", "idle low polarity", 32'(spi_cs), 32'h0);

    report();
  end
endmodule